// File: doc/BRIEF.md
# Debug Scan Command Decoder

This block sits behind one user data register of a test access port. It gathers command bits serially while the port is shifting, and it acts on the gathered command when the port signals an update. One shift register holds two kinds of command. Which kind it is depends on the last bit shifted in. A set top bit picks which debug sub-module is active. A clear top bit sends an opcode to the sub-module that is currently active.

Each sub-module has a small bank of internal control registers, and the block keeps its own selected register index for every sub-module. No opcode reads a register. To read one, the host runs a capture, which loads the selected register of the active sub-module into the shift register, and then shifts a NOP while the value comes out on `tdo`. Burst opcodes are not carried out here. They are passed on as a one-cycle start strobe that carries the opcode, the module, the start address and the word count.

A three-state scan tracker moves through `ST_IDLE`, `ST_LOADED` and `ST_SHIFT`. A capture moves any state to `ST_LOADED`. A shift moves `ST_IDLE` or `ST_LOADED` to `ST_SHIFT`. An update moves `ST_LOADED` or `ST_SHIFT` to `ST_IDLE`. A command is carried out only on the update that leaves `ST_SHIFT`.

Top module: `dbgcmd_decoder`

## Requirements
- R1: While `trst_n` is low, and after it is released, the active module is 0, every per-module register index is 0, every control register is 0, `burst_go` is 0 and `tdo` is 0.
- R2: Bits are shifted in least-significant first while `sel` and `shift_dr` are high, and `tdo` presents the bit about to leave. A capture loads the selected register of the active module, zero-extended, so the next DATA_W shifts return it on `tdo` LSB first.
- R3: A command whose top bit (last bit shifted) is 1 is a module select, and the 2 bits below that bit are the module index, so the command is 3 bits long. Indexes 0 to 2 become active. Index 3 leaves the active module unchanged.
- R4: A top bit of 0 followed by opcode 0xD and then a 2-bit register index sets the selected index of the active module only. Control register contents do not change.
- R5: Opcode 0x9 carries a 2-bit index and then a DATA_W-bit payload below the opcode. It writes the payload into that register of the active module and makes that register the selected one.
- R6: Opcode 0x0 (NOP) changes no state. It is the command shifted during a readback.
- R7: Opcodes 0x1, 0x2 and 0x3 (burst write of 8-, 16- and 32-bit words) and 0x5, 0x6 and 0x7 (burst read of the same sizes) raise `burst_go` for exactly one cycle after the update. During that cycle `burst_op`, the active module, the 32-bit address below the opcode and the 16-bit count below the address are presented.
- R8: Each module keeps its selected register index and its register contents while other modules are active.
- R9: A command is carried out at most once. An update that comes with no shift since the last capture or update has no effect.
- R10: While `sel` is low, capture, shift and update are all ignored.
- R11: Opcodes 0x4, 0x8, 0xA, 0xB, 0xC, 0xE and 0xF change no index and no register, and they raise no burst strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test-logic reset, active low, asynchronous |
| sel | input | 1 | This data register is the one chosen by the port's instruction |
| capture_dr | input | 1 | Port is in the capture state |
| shift_dr | input | 1 | Port is in the shift state |
| update_dr | input | 1 | Port is in the update state |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the shift register |
| burst_go | output | 1 | One-cycle burst start strobe |
| burst_op | output | 4 | Burst opcode |
| burst_mod | output | MOD_W | Module the burst is aimed at |
| burst_addr | output | ADDR_W | Burst start address |
| burst_cnt | output | CNT_W | Burst word count |

## Verification
The hardest state to reach is the one where several modules each hold a different selected index while a different module is active. It has to be built up with select and write commands, then module switches, and then checked through readbacks alone. The stimulus first writes two registers in module 0 and moves its index back to the first of them. It then writes module 1 at a high index, moves module 2 to a new index, and tries the invalid module 3. Every readback after a switch must return the value that the switched-to module kept. A second hard case is the stray update with no shift before it. The bench follows a burst command with a lone update pulse and with a capture-then-update pair, and the scoreboard flags any extra strobe.

// File: rtl/dbgcmd_pkg.sv
package dbgcmd_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OP_NOP     = 4'h0;
    localparam logic [OPC_W-1:0] OP_BWR8    = 4'h1;
    localparam logic [OPC_W-1:0] OP_BWR16   = 4'h2;
    localparam logic [OPC_W-1:0] OP_BWR32   = 4'h3;
    localparam logic [OPC_W-1:0] OP_BRD8    = 4'h5;
    localparam logic [OPC_W-1:0] OP_BRD16   = 4'h6;
    localparam logic [OPC_W-1:0] OP_BRD32   = 4'h7;
    localparam logic [OPC_W-1:0] OP_REG_WR  = 4'h9;
    localparam logic [OPC_W-1:0] OP_REG_SEL = 4'hD;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOADED = 2'd1,
        ST_SHIFT  = 2'd2
    } scan_st_e;

    function automatic logic is_burst(input logic [OPC_W-1:0] op);
        return (op == OP_BWR8) || (op == OP_BWR16) || (op == OP_BWR32) ||
               (op == OP_BRD8) || (op == OP_BRD16) || (op == OP_BRD32);
    endfunction

endpackage

// File: rtl/dbgcmd_shreg.sv
module dbgcmd_shreg #(
    parameter int SR_W   = 53,
    parameter int LOAD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              shift_en,
    input  logic              tdi,
    input  logic [LOAD_W-1:0] load_val,
    output logic [SR_W-1:0]   sr_q,
    output logic              tdo
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (cap_en) begin
            sr_q <= SR_W'(load_val);
        end else if (shift_en) begin
            sr_q <= {tdi, sr_q[SR_W-1:1]};
        end
    end

    assign tdo = sr_q[0];

endmodule

// File: rtl/dbgcmd_regbank.sv
module dbgcmd_regbank #(
    parameter int NUM_MODS = 3,
    parameter int MOD_W    = 2,
    parameter int IDX_W    = 2,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_en,
    input  logic              wr_en,
    input  logic [MOD_W-1:0]  mod,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data
);

    localparam int NUM_REGS = 1 << IDX_W;

    logic [DATA_W-1:0] mod_rd [NUM_MODS];

    for (genvar m = 0; m < NUM_MODS; m++) begin : g_mod
        logic [IDX_W-1:0]  idx_q;
        logic [DATA_W-1:0] regs_q [NUM_REGS];
        logic              hit;

        assign hit = (mod == MOD_W'(m));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                idx_q <= '0;
                for (int r = 0; r < NUM_REGS; r++) begin
                    regs_q[r] <= '0;
                end
            end else begin
                if ((sel_en || wr_en) && hit) begin
                    idx_q <= idx;
                end
                if (wr_en && hit) begin
                    regs_q[idx] <= wdata;
                end
            end
        end

        assign mod_rd[m] = regs_q[idx_q];
    end

    always_comb begin
        rd_data = '0;
        for (int m = 0; m < NUM_MODS; m++) begin
            if (mod == MOD_W'(m)) begin
                rd_data = mod_rd[m];
            end
        end
    end

endmodule

// File: rtl/dbgcmd_decoder.sv
module dbgcmd_decoder #(
    parameter int NUM_MODS = 3,
    parameter int MOD_W    = 2,
    parameter int IDX_W    = 2,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              sel,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    output logic              burst_go,
    output logic [3:0]        burst_op,
    output logic [MOD_W-1:0]  burst_mod,
    output logic [ADDR_W-1:0] burst_addr,
    output logic [CNT_W-1:0]  burst_cnt
);
    import dbgcmd_pkg::*;

    localparam int REG_BODY = IDX_W + DATA_W;
    localparam int BUR_BODY = ADDR_W + CNT_W;
    localparam int BODY_W   = (REG_BODY > BUR_BODY) ? REG_BODY : BUR_BODY;
    localparam int SR_W     = 1 + OPC_W + BODY_W;
    localparam int TOP      = SR_W - 1;
    localparam int OPC_HI   = TOP - 1;
    localparam int BODY_HI  = OPC_HI - OPC_W;

    scan_st_e          st, st_nxt;
    logic              cap, shf, upd, exec;
    logic [SR_W-1:0]   sr;
    logic [DATA_W-1:0] rd_data;
    logic [MOD_W-1:0]  act_mod;

    logic              is_msel;
    logic [MOD_W-1:0]  msel_idx;
    logic [OPC_W-1:0]  opc;
    logic [IDX_W-1:0]  f_idx;
    logic [DATA_W-1:0] f_data;
    logic [ADDR_W-1:0] f_addr;
    logic [CNT_W-1:0]  f_cnt;
    logic              do_sel, do_wr, do_burst, do_msel;

    assign cap = sel && capture_dr;
    assign shf = sel && shift_dr;
    assign upd = sel && update_dr;

    // Scan tracker: next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (cap)      st_nxt = ST_LOADED;
                else if (shf) st_nxt = ST_SHIFT;
            end
            ST_LOADED: begin
                if (shf)      st_nxt = ST_SHIFT;
                else if (upd) st_nxt = ST_IDLE;
            end
            ST_SHIFT: begin
                if (cap)      st_nxt = ST_LOADED;
                else if (upd) st_nxt = ST_IDLE;
            end
            default:          st_nxt = ST_IDLE;
        endcase
    end

    // Scan tracker: state register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st <= ST_IDLE;
        else         st <= st_nxt;
    end

    assign exec = (st == ST_SHIFT) && upd && !cap;

    dbgcmd_shreg #(.SR_W(SR_W), .LOAD_W(DATA_W)) i_shreg (
        .clk      (tck),
        .rst_n    (trst_n),
        .cap_en   (cap),
        .shift_en (shf && !cap),
        .tdi      (tdi),
        .load_val (rd_data),
        .sr_q     (sr),
        .tdo      (tdo)
    );

    // Field decode from the top of the shift register
    assign is_msel  = sr[TOP];
    assign msel_idx = sr[TOP-1 -: MOD_W];
    assign opc      = sr[OPC_HI -: OPC_W];
    assign f_idx    = sr[BODY_HI -: IDX_W];
    assign f_data   = sr[BODY_HI-IDX_W -: DATA_W];
    assign f_addr   = sr[BODY_HI -: ADDR_W];
    assign f_cnt    = sr[BODY_HI-ADDR_W -: CNT_W];

    assign do_msel  = exec && is_msel && ({1'b0, msel_idx} < (MOD_W+1)'(NUM_MODS));
    assign do_sel   = exec && !is_msel && (opc == OP_REG_SEL);
    assign do_wr    = exec && !is_msel && (opc == OP_REG_WR);
    assign do_burst = exec && !is_msel && is_burst(opc);

    dbgcmd_regbank #(
        .NUM_MODS (NUM_MODS),
        .MOD_W    (MOD_W),
        .IDX_W    (IDX_W),
        .DATA_W   (DATA_W)
    ) i_regbank (
        .clk     (tck),
        .rst_n   (trst_n),
        .sel_en  (do_sel),
        .wr_en   (do_wr),
        .mod     (act_mod),
        .idx     (f_idx),
        .wdata   (f_data),
        .rd_data (rd_data)
    );

    // Registered outputs and active module
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            act_mod    <= '0;
            burst_go   <= 1'b0;
            burst_op   <= '0;
            burst_mod  <= '0;
            burst_addr <= '0;
            burst_cnt  <= '0;
        end else begin
            burst_go <= do_burst;
            if (do_msel) begin
                act_mod <= msel_idx;
            end
            if (do_burst) begin
                burst_op   <= opc;
                burst_mod  <= act_mod;
                burst_addr <= f_addr;
                burst_cnt  <= f_cnt;
            end
        end
    end

endmodule

// File: rtl/dbgcmd_decoder_chk.sv
module dbgcmd_decoder_chk #(
    parameter int MOD_W  = 2,
    parameter int DATA_W = 32
) (
    input logic                 tck,
    input logic                 trst_n,
    input logic                 sel,
    input logic                 capture_dr,
    input logic                 update_dr,
    input logic                 tdo,
    input logic                 burst_go,
    input logic [DATA_W-1:0]    rd_data,
    input logic [MOD_W-1:0]     act_mod,
    input dbgcmd_pkg::scan_st_e st
);

    // R2
    cap_load_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (sel && capture_dr) |=> (tdo == $past(rd_data[0])));

    // R7
    burst_pulse_chk: assert property (@(posedge tck) disable iff (!trst_n)
        burst_go |=> !burst_go);

    // R9
    burst_src_chk: assert property (@(posedge tck) disable iff (!trst_n)
        burst_go |-> $past(sel && update_dr && (st == dbgcmd_pkg::ST_SHIFT)));

    // R10
    nosel_mod_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !sel |=> $stable(act_mod));

    // R10
    nosel_burst_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !sel |=> !burst_go);

endmodule

bind dbgcmd_decoder dbgcmd_decoder_chk #(.MOD_W(MOD_W), .DATA_W(DATA_W)) i_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .sel        (sel),
    .capture_dr (capture_dr),
    .update_dr  (update_dr),
    .tdo        (tdo),
    .burst_go   (burst_go),
    .rd_data    (rd_data),
    .act_mod    (act_mod),
    .st         (st)
);

// File: tb/test_dbgcmd_decoder.sv
module test_dbgcmd_decoder;
    localparam int DW = 32;

    logic tck = 0, trst_n = 0, sel = 1;
    logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic        tdo, burst_go;
    logic [3:0]  burst_op;
    logic [1:0]  burst_mod;
    logic [31:0] burst_addr;
    logic [15:0] burst_cnt;

    always #10 tck = ~tck;

    dbgcmd_decoder i_dbgcmd_decoder (
        .tck(tck), .trst_n(trst_n), .sel(sel), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .burst_go(burst_go), .burst_op(burst_op), .burst_mod(burst_mod),
        .burst_addr(burst_addr), .burst_cnt(burst_cnt)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  m;
        logic [31:0] a;
        logic [15:0] c;
    } burst_t;

    burst_t exp_q[$];
    int checks = 0, fails = 0;
    logic [31:0] mreg [3][4];
    int midx [3];
    int mact = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops expected burst items as strobes appear
    always @(negedge tck) begin
        if (trst_n && burst_go) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected burst strobe", 64'd1, 64'd0);
            end else begin
                burst_t e;
                e = exp_q.pop_front();
                check({burst_op, burst_mod, burst_addr, burst_cnt} == e, "R7 burst fields",
                      64'({burst_op, burst_mod, burst_addr, burst_cnt}), 64'(e));
            end
        end
    end

    task automatic scan(input logic [63:0] v, input int n, input bit upd, output logic [63:0] got);
        got = '0;
        capture_dr = 1; @(negedge tck); capture_dr = 0;
        for (int i = 0; i < n; i++) begin
            shift_dr = 1; tdi = v[i]; got[i] = tdo;
            @(negedge tck);
        end
        shift_dr = 0; tdi = 0;
        if (upd) begin update_dr = 1; @(negedge tck); update_dr = 0; end
        @(negedge tck);
    endtask

    task automatic readback(input string req);
        logic [63:0] got;
        logic [31:0] e;
        e = mreg[mact][midx[mact]];
        scan(64'd0, DW + 5, 1'b1, got);
        check(got[31:0] == e, req, 64'(got[31:0]), 64'(e));
    endtask

    task automatic mod_sel(input int m);
        logic [63:0] g;
        scan(64'(3'b100 | m), 3, 1'b1, g);
        if (sel && m < 3) mact = m;
    endtask

    task automatic reg_sel(input int idx);
        logic [63:0] g;
        scan(64'({1'b0, 4'hD, 2'(idx)}), 7, 1'b1, g);
        if (sel) midx[mact] = idx;
    endtask

    task automatic raw_cmd(input logic [3:0] op, input int idx, input logic [31:0] d);
        logic [63:0] g;
        scan(64'({1'b0, op, 2'(idx), d}), 39, 1'b1, g);
        if (sel && op == 4'h9) begin
            midx[mact] = idx;
            mreg[mact][idx] = d;
        end
    endtask

    task automatic burst(input logic [3:0] op, input logic [31:0] a, input logic [15:0] c);
        logic [63:0] g;
        if (sel) exp_q.push_back({op, 2'(mact), a, c});
        scan(64'({1'b0, op, a, c}), 53, 1'b1, g);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        check(1'b0, "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        logic [63:0] g;
        for (int m = 0; m < 3; m++) begin
            midx[m] = 0;
            for (int r = 0; r < 4; r++) mreg[m][r] = '0;
        end
        repeat (3) @(negedge tck);
        check(tdo == 1'b0, "R1 tdo in reset", 64'(tdo), 64'd0);
        check(burst_go == 1'b0, "R1 burst_go in reset", 64'(burst_go), 64'd0);
        trst_n = 1;
        @(negedge tck);
        readback("R1 R2 readback after reset");

        raw_cmd(4'h9, 1, 32'hA5A5_0001);
        readback("R5 write m0 r1");
        raw_cmd(4'h9, 2, 32'h1234_5678);
        readback("R5 write m0 r2");
        reg_sel(1);
        readback("R4 select m0 r1");
        scan(64'd0, 5, 1'b1, g);
        readback("R6 nop keeps state");

        mod_sel(1);
        readback("R3 module 1 active");
        raw_cmd(4'h9, 3, 32'hCAFE_F00D);
        readback("R5 write m1 r3");
        mod_sel(0);
        readback("R8 m0 index kept");
        mod_sel(3);
        readback("R3 invalid module ignored");
        mod_sel(2);
        reg_sel(2);
        readback("R4 select in m2");
        mod_sel(1);
        readback("R8 m1 kept across m2 select");

        raw_cmd(4'hA, 0, 32'hFFFF_FFFF);
        readback("R11 opcode A no effect");
        raw_cmd(4'h4, 0, 32'h0F0F_0F0F);
        reg_sel(0);
        readback("R11 payload not written");

        burst(4'h1, 32'h1000_0000, 16'd4);
        burst(4'h7, 32'hFFFF_FFFC, 16'd1);
        mod_sel(0);
        burst(4'h2, 32'h0000_0400, 16'hFFFF);
        burst(4'h5, 32'h8000_0001, 16'd9);
        update_dr = 1; @(negedge tck); update_dr = 0;
        capture_dr = 1; @(negedge tck); capture_dr = 0;
        update_dr = 1; @(negedge tck); update_dr = 0;
        repeat (3) @(negedge tck);

        sel = 0;
        burst(4'h3, 32'h2222_2222, 16'd2);
        raw_cmd(4'h9, 1, 32'hDEAD_BEEF);
        mod_sel(2);
        sel = 1;
        readback("R10 ignored while deselected");

        repeat (3) @(negedge tck);
        check(exp_q.size() == 0, "R9 R7 every burst seen once", 64'(exp_q.size()), 64'd0);
        check(burst_go == 1'b0, "R7 strobe low at end", 64'(burst_go), 64'd0);
        finish_run();
    end
endmodule